// File: doc/BRIEF.md
# Masked Interrupt Flag Controller

This block gathers three interrupt causes for a small processor core: a timer overflow pulse, a change on an 8-bit input port, and a falling edge on port pin 0 when that pin is set up as an external interrupt line. Each cause latches into a sticky flag bit. A per-cause enable register gates those flags, and a global enable gates the request to the core. The core sets the global enable with an enable command and clears it with a disable command. Taking an interrupt also clears it.

Software reaches the flag and enable registers through a small synchronous register bus. Reading the flag address returns only the flags whose enable bits are set. Reading the port address returns the live port value, and a read strobe at that address captures the snapshot that the change detector compares against. While the core sleeps, any enabled pending flag raises a wake signal. A second output tells the core whether to resume in line (global enable clear) or to branch to the fixed interrupt vector 0x008 (global enable set).

Top module: `irq_flag_ctrl`

## Requirements
- R1: A cause sets its flag on the clock edge after the event, whatever the enable register holds. Flag bit 0 is timer overflow, bit 1 is port change and bit 2 is the external interrupt.
- R2: A write to the flag address (address 0) clears each flag whose data bit is 0 and leaves flags whose data bit is 1 unchanged. An event in the same cycle as the write wins, so that flag ends up set.
- R3: A read of address 0 returns the flags ANDed with the enable register in bits 2:0, and 0 in bits 7:3.
- R4: The enable register at address 1 is writable and reads back in bits 2:0, with 0 in bits 7:3. A 1 enables the cause in the same bit position.
- R5: The port-change flag sets in any cycle where the port differs from the snapshot. A read strobe at address 2 loads the snapshot from the port, and that address reads the live port. The snapshot resets to 0.
- R6: While the external-interrupt select is high, pin 0 is left out of the change comparison. While the select is low, pin 0 counts like the other pins.
- R7: A falling edge on pin 0 sets the external flag only while the external-interrupt select is high.
- R8: The enable command sets the global enable. The disable command and the interrupt-taken strobe clear it, and either one wins over an enable command in the same cycle.
- R9: The interrupt request is high exactly when the global enable is set and at least one flag is both set and enabled. The vector output is always 0x008.
- R10: While sleeping, wake is high exactly when an enabled flag is pending. The vector-on-wake output is wake ANDed with the global enable; when it is low, execution resumes in line.
- R11: After reset all flags, all enable bits and the global enable are 0, and request and wake are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_ovf | input | 1 | Timer overflow pulse |
| port_in | input | 8 | Input port pins |
| ext_sel | input | 1 | Pin 0 acts as the external interrupt line |
| reg_addr | input | 2 | Register address: 0 flags, 1 enables, 2 port |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; at address 2 it loads the snapshot |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the current address |
| cmd_eni | input | 1 | Set the global enable |
| cmd_disi | input | 1 | Clear the global enable |
| irq_take | input | 1 | Core is taking the interrupt |
| sleeping | input | 1 | Core is in sleep |
| irq_req | output | 1 | Interrupt request |
| irq_vector | output | 10 | Fixed interrupt vector address |
| wake | output | 1 | Wake from sleep |
| wake_vec | output | 1 | On wake, branch to the vector instead of resuming |

## Verification
The hardest case to reach from the ports is telling the two roles of pin 0 apart. One edge on that pin can feed the change detector, the external-edge detector, both or neither, depending on the select level and on what the snapshot holds. The stimulus first moves the snapshot to a known pin 0 value through a port read. It then flips the select and drives rising and falling edges in turn. The enable register is set to expose one flag at a time, so each path is seen alone. A second hard case is a clearing write landing in the same cycle as an event; the bench aligns the two on one clock edge.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  localparam int NSRC    = 3;
  localparam int SRC_TMR = 0;
  localparam int SRC_CHG = 1;
  localparam int SRC_EXT = 2;

  typedef enum logic [1:0] {
    RA_FLAG = 2'd0,
    RA_MASK = 2'd1,
    RA_PORT = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;

  // Next flag value: a write can only clear bits (data 0), events always set.
  function automatic logic [NSRC-1:0] flag_next(
    input logic [NSRC-1:0] cur,
    input logic            wr_en,
    input logic [NSRC-1:0] wd,
    input logic [NSRC-1:0] ev
  );
    logic [NSRC-1:0] kept;
    kept = wr_en ? (cur & wd) : cur;
    return kept | ev;
  endfunction

  // Software view of the flag register.
  function automatic logic [NSRC-1:0] masked_view(
    input logic [NSRC-1:0] flags,
    input logic [NSRC-1:0] mask
  );
    return flags & mask;
  endfunction

  function automatic logic any_pending(
    input logic [NSRC-1:0] flags,
    input logic [NSRC-1:0] mask
  );
    return |masked_view(flags, mask);
  endfunction

endpackage

// File: rtl/irq_port_watch.sv
module irq_port_watch #(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] port_in,
  input  logic              ext_sel,
  input  logic              snap_take,
  output logic [PORT_W-1:0] snap_q,
  output logic              chg_evt,
  output logic              ext_evt
);

  logic              pin0_q;
  logic [PORT_W-1:0] diff;
  logic [PORT_W-1:0] cmp_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      pin0_q <= 1'b0;
    end else begin
      if (snap_take) snap_q <= port_in;
      pin0_q <= port_in[0];
    end
  end

  // Pin 0 drops out of the comparison while it serves as the external line.
  generate
    for (genvar i = 0; i < PORT_W; i++) begin : g_cmp
      if (i == 0) begin : g_pin0
        assign cmp_mask[i] = ~ext_sel;
      end else begin : g_pinx
        assign cmp_mask[i] = 1'b1;
      end
    end
  endgenerate

  assign diff    = (port_in ^ snap_q) & cmp_mask;
  assign chg_evt = |diff;
  assign ext_evt = ext_sel & pin0_q & ~port_in[0];

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_ctrl_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev,
  input  logic         flag_wr,
  input  logic         mask_wr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] flags_q,
  output logic [N-1:0] mask_q
);

  logic [N-1:0] flags_d;

  always_comb begin
    flags_d = flag_next(flags_q, flag_wr, wdata, ev);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      mask_q  <= '0;
    end else begin
      flags_q <= flags_d;
      if (mask_wr) mask_q <= wdata;
    end
  end

endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int              VEC_W  = 10,
  parameter logic [VEC_W-1:0] VECTOR = 10'h008
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_eni,
  input  logic             cmd_disi,
  input  logic             irq_take,
  input  logic             sleeping,
  input  logic             pending,
  output logic             gie_q,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vector,
  output logic             wake,
  output logic             wake_vec
);

  logic gie_d;

  always_comb begin
    gie_d = gie_q;
    if (irq_take || cmd_disi) gie_d = 1'b0;
    else if (cmd_eni)         gie_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gie_q <= 1'b0;
    else        gie_q <= gie_d;
  end

  assign irq_req    = gie_q & pending;
  assign irq_vector = VECTOR;
  assign wake       = sleeping & pending;
  assign wake_vec   = wake & gie_q;

endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int               PORT_W = 8,
  parameter int               DATA_W = 8,
  parameter int               VEC_W  = 10,
  parameter logic [VEC_W-1:0] VECTOR = 10'h008
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              timer_ovf,
  input  logic [PORT_W-1:0] port_in,
  input  logic              ext_sel,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cmd_eni,
  input  logic              cmd_disi,
  input  logic              irq_take,
  input  logic              sleeping,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vector,
  output logic              wake,
  output logic              wake_vec
);

  localparam int HI_W = DATA_W - NSRC;

  // Named internal events, visible to the bound checker.
  logic              sel_flag, sel_mask, sel_port;
  logic              flag_wr, mask_wr, snap_take;
  logic              chg_evt, ext_evt;
  logic [NSRC-1:0]   ev;
  logic [NSRC-1:0]   flags_q, mask_q;
  logic [PORT_W-1:0] snap_q;
  logic              pending;
  logic              gie_q;
  logic              unused_wdata_hi;

  assign sel_flag  = (reg_addr == RA_FLAG);
  assign sel_mask  = (reg_addr == RA_MASK);
  assign sel_port  = (reg_addr == RA_PORT);
  assign flag_wr   = reg_wr & sel_flag;
  assign mask_wr   = reg_wr & sel_mask;
  assign snap_take = reg_rd & sel_port;
  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NSRC];

  irq_port_watch #(.PORT_W(PORT_W)) u_watch (
    .clk       (clk),
    .rst_n     (rst_n),
    .port_in   (port_in),
    .ext_sel   (ext_sel),
    .snap_take (snap_take),
    .snap_q    (snap_q),
    .chg_evt   (chg_evt),
    .ext_evt   (ext_evt)
  );

  always_comb begin
    ev          = '0;
    ev[SRC_TMR] = timer_ovf;
    ev[SRC_CHG] = chg_evt;
    ev[SRC_EXT] = ext_evt;
  end

  irq_flag_bank #(.N(NSRC)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev      (ev),
    .flag_wr (flag_wr),
    .mask_wr (mask_wr),
    .wdata   (reg_wdata[NSRC-1:0]),
    .flags_q (flags_q),
    .mask_q  (mask_q)
  );

  assign pending = any_pending(flags_q, mask_q);

  irq_gate #(.VEC_W(VEC_W), .VECTOR(VECTOR)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_eni    (cmd_eni),
    .cmd_disi   (cmd_disi),
    .irq_take   (irq_take),
    .sleeping   (sleeping),
    .pending    (pending),
    .gie_q      (gie_q),
    .irq_req    (irq_req),
    .irq_vector (irq_vector),
    .wake       (wake),
    .wake_vec   (wake_vec)
  );

  always_comb begin
    reg_rdata = '0;
    if (sel_flag)      reg_rdata = {{HI_W{1'b0}}, masked_view(flags_q, mask_q)};
    else if (sel_mask) reg_rdata = {{HI_W{1'b0}}, mask_q};
    else if (sel_port) reg_rdata = DATA_W'(port_in);
  end

endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk #(
  parameter int PORT_W = 8,
  parameter int N      = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N-1:0]      ev,
  input logic [N-1:0]      flags_q,
  input logic              flag_wr,
  input logic [N-1:0]      wd,
  input logic              cmd_eni,
  input logic              cmd_disi,
  input logic              irq_take,
  input logic              gie_q,
  input logic              irq_req,
  input logic              wake_vec,
  input logic              ext_sel,
  input logic [PORT_W-1:0] port_in,
  input logic [PORT_W-1:0] snap_q,
  input logic              chg_evt
);

  AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & $past(ev)) == $past(ev))); // R1

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R2

  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && ev == '0) |=> (flags_q == ($past(flags_q) & $past(wd)))); // R2

  AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_disi || irq_take) |=> !gie_q); // R8

  AST_ENABLE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_eni && !cmd_disi && !irq_take) |=> gie_q); // R8

  AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> gie_q); // R9

  AST_WAKE_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    wake_vec |-> irq_req); // R10

  AST_PIN0_EXCLUDED: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sel && port_in[PORT_W-1:1] == snap_q[PORT_W-1:1]) |-> !chg_evt); // R6

endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(.PORT_W(PORT_W), .N(irq_ctrl_pkg::NSRC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ev       (ev),
  .flags_q  (flags_q),
  .flag_wr  (flag_wr),
  .wd       (reg_wdata[irq_ctrl_pkg::NSRC-1:0]),
  .cmd_eni  (cmd_eni),
  .cmd_disi (cmd_disi),
  .irq_take (irq_take),
  .gie_q    (gie_q),
  .irq_req  (irq_req),
  .wake_vec (wake_vec),
  .ext_sel  (ext_sel),
  .port_in  (port_in),
  .snap_q   (snap_q),
  .chg_evt  (chg_evt)
);

// File: tb/sim_irq_flag_ctrl.sv
module sim_irq_flag_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       timer_ovf = 1'b0;
  logic [7:0] port_in = 8'h01;
  logic       ext_sel = 1'b1;
  logic [1:0] reg_addr = 2'd3;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       cmd_eni = 1'b0;
  logic       cmd_disi = 1'b0;
  logic       irq_take = 1'b0;
  logic       sleeping = 1'b0;
  logic       irq_req;
  logic [9:0] irq_vector;
  logic       wake;
  logic       wake_vec;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  irq_flag_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .timer_ovf(timer_ovf), .port_in(port_in),
    .ext_sel(ext_sel), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_eni(cmd_eni),
    .cmd_disi(cmd_disi), .irq_take(irq_take), .sleeping(sleeping),
    .irq_req(irq_req), .irq_vector(irq_vector), .wake(wake), .wake_vec(wake_vec)
  );

  // {enable[2:0], events[2:0], expected flag read[2:0], expected request}
  localparam logic [9:0] VEC [8] = '{
    {3'b111, 3'b001, 3'b001, 1'b1},
    {3'b111, 3'b010, 3'b010, 1'b1},
    {3'b111, 3'b100, 3'b100, 1'b1},
    {3'b000, 3'b111, 3'b000, 1'b0},
    {3'b101, 3'b111, 3'b101, 1'b1},
    {3'b010, 3'b101, 3'b000, 1'b0},
    {3'b110, 3'b110, 3'b110, 1'b1},
    {3'b011, 3'b100, 3'b000, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic snap();
    @(negedge clk);
    reg_addr = 2'd2; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic rdchk(input logic [1:0] a, input logic [7:0] exp, input string req);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic pulse_cmd(input logic e, input logic d, input logic t);
    @(negedge clk);
    cmd_eni = e; cmd_disi = d; irq_take = t;
    @(negedge clk);
    cmd_eni = 1'b0; cmd_disi = 1'b0; irq_take = 1'b0;
    #1;
  endtask

  // One cycle of events: timer pulse, toggle pin 3, falling edge on pin 0.
  task automatic evt(input logic t, input logic c, input logic x);
    @(negedge clk);
    timer_ovf = t;
    if (c) port_in[3] = ~port_in[3];
    if (x) port_in[0] = 1'b0;
    @(negedge clk);
    timer_ovf = 1'b0;
    port_in[0] = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [9:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    rdchk(2'd0, 8'h00, "R11 flags");
    rdchk(2'd1, 8'h00, "R11 enables");
    chk("R11 irq_req", irq_req, 0);
    chk("R11 wake", wake, 0);
    chk("R9 vector", irq_vector, 10'h008);

    // Table walk: R3 masked readback and R9 request
    for (int i = 0; i < 8; i++) begin
      v = VEC[i];
      wr(2'd0, 8'h00);
      wr(2'd1, {5'b0, v[9:7]});
      pulse_cmd(1'b1, 1'b0, 1'b0);
      evt(v[4], v[5], v[6]);
      snap();
      rdchk(2'd0, {5'b0, v[3:1]}, "R3 masked read");
      chk("R9 request", irq_req, v[0]);
    end

    // R8 global enable control
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h01);
    evt(1'b1, 1'b0, 1'b0);
    #1; chk("R8 enabled request", irq_req, 1);
    pulse_cmd(1'b0, 1'b0, 1'b1);
    chk("R8 take clears", irq_req, 0);
    pulse_cmd(1'b1, 1'b1, 1'b0);
    chk("R8 disable wins", irq_req, 0);
    pulse_cmd(1'b1, 1'b0, 1'b0);
    chk("R8 enable", irq_req, 1);
    pulse_cmd(1'b0, 1'b1, 1'b0);
    chk("R8 disable", irq_req, 0);

    // R10 wake decisions
    sleeping = 1'b1; #1;
    chk("R10 wake", wake, 1);
    chk("R10 resume in line", wake_vec, 0);
    pulse_cmd(1'b1, 1'b0, 1'b0);
    chk("R10 vector on wake", wake_vec, 1);
    wr(2'd0, 8'h00); #1;
    chk("R10 no pending", wake, 0);
    sleeping = 1'b0;
    pulse_cmd(1'b0, 1'b1, 1'b0);

    // R2 selective clear and event priority
    wr(2'd1, 8'h07);
    evt(1'b1, 1'b1, 1'b1);
    snap();
    rdchk(2'd0, 8'h07, "R2 all set");
    wr(2'd0, 8'h05);
    rdchk(2'd0, 8'h05, "R2 clear bit1 only");
    @(negedge clk);
    reg_addr = 2'd0; reg_wdata = 8'h00; reg_wr = 1'b1; timer_ovf = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; timer_ovf = 1'b0;
    rdchk(2'd0, 8'h01, "R2 event wins");

    // R1 flags latch while disabled
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    evt(1'b0, 1'b0, 1'b1);
    snap();
    rdchk(2'd0, 8'h00, "R1 hidden");
    wr(2'd1, 8'h04);
    rdchk(2'd0, 8'h04, "R1 latched");

    // R4 enable register width
    wr(2'd1, 8'hFF);
    rdchk(2'd1, 8'h07, "R4 readback");

    // R5 snapshot comparison
    @(negedge clk); ext_sel = 1'b0;
    snap();
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h02);
    rdchk(2'd0, 8'h00, "R5 stable");
    @(negedge clk); port_in[6] = ~port_in[6];
    @(negedge clk);
    rdchk(2'd0, 8'h02, "R5 change");
    rdchk(2'd2, port_in, "R5 port read");
    snap();
    wr(2'd0, 8'h00);
    repeat (3) @(negedge clk);
    rdchk(2'd0, 8'h00, "R5 after snapshot");

    // R6 pin 0 counts only when not the external line
    @(negedge clk); port_in[0] = 1'b0;
    @(negedge clk);
    rdchk(2'd0, 8'h02, "R6 pin0 as port pin");
    wr(2'd1, 8'h06);
    snap();
    wr(2'd0, 8'h00);
    @(negedge clk); port_in[0] = 1'b1; ext_sel = 1'b1;
    @(negedge clk);
    rdchk(2'd0, 8'h00, "R6 pin0 excluded");
    @(negedge clk); port_in[0] = 1'b0;
    @(negedge clk);
    rdchk(2'd0, 8'h04, "R7 edge with select");

    // R7 no external flag without select
    @(negedge clk); port_in[0] = 1'b1;
    snap();
    wr(2'd1, 8'h04);
    wr(2'd0, 8'h00);
    @(negedge clk); ext_sel = 1'b0;
    @(negedge clk); port_in[0] = 1'b0;
    @(negedge clk);
    rdchk(2'd0, 8'h00, "R7 no edge without select");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule